// File: doc/BRIEF.md
# Per-Second Reference Drift Meter

This block tells a measurement module how far the shared reference oscillator has strayed from its nominal rate. It runs on the reference clock and watches a pulse-per-second input that is already synchronised to that clock. It counts the reference cycles from one rising pulse edge to the next, subtracts the expected per-second count, and publishes the signed result for the second that just ended. The result can then be attached to outgoing records next to the coarse wall-clock stamp and the fine tick count.

A one-cycle valid strobe marks each new result. The published value holds until the next one replaces it. If the pulse goes missing for longer than the period counter can span, an out-of-range flag is raised. The edge that finally arrives then gives no result and simply starts a fresh measurement. At its defaults the block expects 10,000,000 cycles per second and uses a 25-bit period counter.

Top module: `drift_meter`

## Requirements
- R1: While reset is asserted, and on release, `driftOut` is 0 and `driftValid` and `outOfRange` are low.
- R2: A rising edge of `ppsIn` is a clock edge at which `ppsIn` is sampled high after being sampled low. The first such edge after reset only starts a measurement and produces no valid result.
- R3: If the previous edge came N clocks earlier, an edge produces `driftValid` high for exactly one cycle. The strobe is seen after the second clock edge following the pulse edge, and `driftOut` then equals N minus NOMINAL.
- R4: `driftOut` is two's complement, CNT_W+1 bits wide. Periods shorter than, equal to and longer than NOMINAL give negative, zero and positive values.
- R5: A pulse that stays high for many cycles counts as one edge. A `ppsIn` that is already high when reset is released is not an edge.
- R6: `driftOut` keeps the last published value between valid strobes.
- R7: If no edge arrives 2^CNT_W-1 clocks after the edge that started a measurement, `outOfRange` rises after that clock. The next edge produces no valid result, clears `outOfRange` and starts a new measurement.
- R8: A period of exactly 2^CNT_W-1 clocks is still reported as a valid result, and `outOfRange` stays low during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| ppsIn | input | 1 | Pulse-per-second, synchronised to clk |
| driftOut | output | CNT_W+1 | Signed cycle count of the last second minus NOMINAL |
| driftValid | output | 1 | One-cycle strobe marking a new driftOut |
| outOfRange | output | 1 | Pulse missing for longer than the counter span |

## Verification
The bench builds the block with CNT_W = 6 and NOMINAL = 20, so one nominal second lasts twenty clocks. With these values the counter limit is 63 clocks, so the longest valid period and the timeout are only a few dozen cycles away. Periods of 3, 17, 20, 25, 40, 63, 64 and 100 clocks cover negative, zero and positive drift, the exact counter limit and the first length past it. Wide pulses and a pulse already high at reset release exercise the edge rule.

// File: rtl/drift_pkg.sv
package drift_pkg;

  // Strobes from control to datapath, one set per clock.
  typedef struct packed {
    logic loadOne;   // a period boundary: counter restarts at one
    logic inc;       // count one more reference cycle
    logic capture;   // latch the finished count as a valid period
  } drift_strobes_t;

endpackage

// File: rtl/drift_ctrl.sv
module drift_ctrl
  import drift_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           ppsIn,
  input  logic           atMax,
  output drift_strobes_t strobes,
  output logic           outOfRange
);

  logic ppsPrev;
  logic armed;
  logic ovfFlag;
  logic ppsEdge;
  logic timeoutNow;

  // Rising edge: high now, low at the previous clock.
  assign ppsEdge    = ppsIn & ~ppsPrev;
  assign timeoutNow = armed & atMax & ~ppsEdge;

  always_comb begin
    strobes         = '0;
    strobes.loadOne = ppsEdge;
    strobes.inc     = armed & ~ppsEdge & ~atMax;
    strobes.capture = ppsEdge & armed & ~ovfFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ppsPrev <= 1'b1;   // a level already high at release is not an edge
      armed   <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      ppsPrev <= ppsIn;
      if (ppsEdge) begin
        armed   <= 1'b1;
        ovfFlag <= 1'b0;
      end else if (timeoutNow) begin
        ovfFlag <= 1'b1;
      end
    end
  end

  assign outOfRange = ovfFlag;

  // R7: a timeout can only follow a started measurement.
  assert_flag_needs_arm_R7: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |-> armed);

endmodule

// File: rtl/drift_datapath.sv
module drift_datapath
  import drift_pkg::*;
#(
  parameter int CNT_W   = 25,
  parameter int NOMINAL = 10_000_000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  drift_strobes_t            strobes,
  output logic                      atMax,
  output logic signed [CNT_W:0]     driftOut,
  output logic                      driftValid
);

  localparam int DRIFT_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic signed [DRIFT_W-1:0] NOM_S = DRIFT_W'(NOMINAL);

  logic [CNT_W-1:0] periodCnt;
  logic [CNT_W-1:0] capReg;
  logic             capPend;

  assign atMax = (periodCnt == CNT_MAX);

  // Period counter: restarts at one on each edge, saturates at the top.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodCnt <= '0;
    end else if (strobes.loadOne) begin
      periodCnt <= CNT_W'(1);
    end else if (strobes.inc) begin
      periodCnt <= periodCnt + CNT_W'(1);
    end
  end

  // Stage one: hold the finished count.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capReg  <= '0;
      capPend <= 1'b0;
    end else begin
      capPend <= strobes.capture;
      if (strobes.capture) capReg <= periodCnt;
    end
  end

  // Stage two: signed difference from nominal.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      driftOut   <= '0;
      driftValid <= 1'b0;
    end else begin
      driftValid <= capPend;
      if (capPend) driftOut <= $signed({1'b0, capReg}) - NOM_S;
    end
  end

  // R6: output only moves together with the strobe.
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !driftValid |-> $stable(driftOut));

endmodule

// File: rtl/drift_meter.sv
module drift_meter
  import drift_pkg::*;
#(
  parameter int CNT_W   = 25,
  parameter int NOMINAL = 10_000_000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ppsIn,
  output logic signed [CNT_W:0] driftOut,
  output logic                  driftValid,
  output logic                  outOfRange
);

  drift_strobes_t strobes;
  logic           atMax;

  drift_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ppsIn      (ppsIn),
    .atMax      (atMax),
    .strobes    (strobes),
    .outOfRange (outOfRange)
  );

  drift_datapath #(
    .CNT_W   (CNT_W),
    .NOMINAL (NOMINAL)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .atMax      (atMax),
    .driftOut   (driftOut),
    .driftValid (driftValid)
  );

  // R3: the result strobe lasts a single cycle.
  assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    driftValid |=> !driftValid);

  // R7: no result emerges from an edge that ended an overlong period.
  assert_no_result_after_timeout_R7: assert property (@(posedge clk) disable iff (!rstN)
    driftValid |-> !$past(outOfRange, 2));

endmodule

// File: tb/tb_drift_meter.sv
module tb_drift_meter;

  localparam int CNT_W   = 6;
  localparam int NOMINAL = 20;
  localparam int NV      = 9;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  ppsIn = 1'b0;
  logic signed [CNT_W:0] driftOut;
  logic                  driftValid;
  logic                  outOfRange;

  int checks = 0;
  int fails  = 0;
  int lastDrift = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  drift_meter #(.CNT_W(CNT_W), .NOMINAL(NOMINAL)) dut (
    .clk(clk), .rstN(rstN), .ppsIn(ppsIn),
    .driftOut(driftOut), .driftValid(driftValid), .outOfRange(outOfRange)
  );

  // Period length, pulse width, expected timeout, expected valid, expected drift.
  localparam int VN [NV] = '{20, 17, 25, 63, 64, 100, 20,  3, 40};
  localparam int VH [NV] = '{ 3,  1, 10, 30,  2,   5, 19,  1,  1};
  localparam bit VO [NV] = '{ 0,  0,  0,  0,  1,   1,  0,  0,  0};
  localparam bit VV [NV] = '{ 1,  1,  1,  1,  0,   0,  1,  1,  1};
  localparam int VD [NV] = '{ 0, -3,  5, 43,  0,   0,  0,-17, 20};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One period: ends with an edge n clocks after the previous one.
  // Checks the outcome of the previous edge in the first two cycles.
  task automatic step(input int n, input int hi, input bit expOvf,
                      input bit pv, input int pd);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (i == 1) begin
        chk(driftValid == 1'b0, "R3 strobe too early", int'(driftValid), 0);
        chk(outOfRange == 1'b0, "R7 flag cleared at edge", int'(outOfRange), 0);
      end
      if (i == 2) begin
        chk(driftValid == pv, "R3/R7 valid strobe", int'(driftValid), int'(pv));
        if (pv) begin
          chk(int'(driftOut) == pd, "R3/R4 drift value", int'(driftOut), pd);
          lastDrift = pd;
        end
      end
      if (i == n) begin
        chk(outOfRange == expOvf, "R7/R8 timeout flag", int'(outOfRange), int'(expOvf));
        chk(int'(driftOut) == lastDrift, "R6 hold", int'(driftOut), lastDrift);
      end
      if (i == hi) ppsIn = 1'b0;
      if (i == n)  ppsIn = 1'b1;
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(driftOut == 0 && !driftValid && !outOfRange, "R1 reset state",
        int'(driftOut) + int'(driftValid) + int'(outOfRange), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(driftOut == 0 && !driftValid && !outOfRange, "R1 after release",
        int'(driftOut) + int'(driftValid) + int'(outOfRange), 0);

    // R2: first edge only starts a measurement
    repeat (5) @(negedge clk);
    ppsIn = 1'b1;
    for (int k = 0; k < NV; k++) begin
      step(VN[k], VH[k], VO[k], (k == 0) ? 1'b0 : VV[k-1], (k == 0) ? 0 : VD[k-1]);
    end
    @(negedge clk);
    chk(driftValid == 1'b0, "R3 strobe too early", int'(driftValid), 0);
    @(negedge clk);
    chk(driftValid == VV[NV-1], "R3 last valid", int'(driftValid), int'(VV[NV-1]));
    chk(int'(driftOut) == VD[NV-1], "R4 last drift", int'(driftOut), VD[NV-1]);
    @(negedge clk);
    chk(driftValid == 1'b0, "R3 single cycle", int'(driftValid), 0);
    ppsIn = 1'b0;

    // R1: mid-run reset clears everything
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(driftOut == 0 && !driftValid && !outOfRange, "R1 mid-run reset",
        int'(driftOut) + int'(driftValid) + int'(outOfRange), 0);

    // R5: pulse already high at release is not an edge
    ppsIn = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    ppsIn = 1'b0;
    repeat (3) @(negedge clk);
    ppsIn = 1'b1;          // first real edge
    lastDrift = 0;
    step(20, 4, 1'b0, 1'b0, 0);   // R2/R5: that edge gave no result
    @(negedge clk);
    @(negedge clk);
    chk(driftValid == 1'b1, "R5 one measured period", int'(driftValid), 1);
    chk(int'(driftOut) == 0, "R5 drift", int'(driftOut), 0);
    ppsIn = 1'b0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule